// File: doc/BRIEF.md
# Pattern Fill-Verify Memory Sequencer

This block exercises the cells of a word-addressed memory with a fixed chain of seven data patterns. For each pattern it first writes every 32-bit word of a window, and only after the whole window is written does it read every word back and compare it against the value that was written. Comparison stops at the first wrong word, and once a pattern has failed no further pattern or window is started. Two pattern sets depend on the word's position inside the current window: a walking one and the word index itself, plain or inverted.

Two coverage modes are offered. In full mode one window spans the whole region. In sampled mode the region is cut into 1 MiB blocks and, for each block, two 2 KiB windows are tested: one at the block's start and one ending at the block's last byte. During the run the block raises a periodic watchdog kick. At the end it pulses `done` and holds either a pass flag or a fail flag. A failure also holds the byte address of the bad word, the value that was expected and the value that was read.

Top module: `patternFillVerify`

## Requirements
- R1: After reset `busy`, `done`, `passed`, `failed`, `memReq`, `wdogKick` and the three failure fields are all 0.
- R2: Passes run in this order, with data depending on pass number and on the word index i inside the window: 0x00000000, 0xFFFFFFFF, 0x55555555, 0xAAAAAAAA, 1 << (i mod 32), i, and the bitwise inverse of i.
- R3: Each pass writes words i = 0..N-1 at byte address windowBase + 4·i on consecutive cycles (`memReq`=1, `memWe`=1). It then reads the same addresses in the same order on consecutive cycles (`memWe`=0). `memRdata` is taken as the answer to a read one cycle after that read, and is compared in that cycle. Each pass ends with one cycle with no request followed by one gap cycle.
- R4: A mismatch ends the run. The cycle after the compare cycle shows `busy`=0, `done`=1 and `failed`=1. At most one further read follows the failing one, and no later pass or window starts.
- R5: `wdogKick` is high in every fill or verify cycle whose word index is a multiple of 1024, and in the gap cycle after each pass. It is low at all other times.
- R6: In sampled mode, with B = regionBytes >> 20, windows of 512 words are taken in this order: base + k·1 MiB, then base + k·1 MiB + 0xFF800, for k = 0..B-1. All seven passes run on a window before the next window starts.
- R7: In full mode a single window starts at `baseAddr` and holds regionBytes/4 words.
- R8: On a failure, `failAddr` (byte address), `failExp` and `failGot` hold their values until the next accepted `start`, which clears them to 0.
- R9: `done` is high for exactly one cycle, in the first idle cycle, together with `passed` (all passes matched) or `failed`. If the region holds no window or no word, `done` and `passed` appear in the cycle after `start`.
- R10: A `start` that arrives while `busy` is high has no effect.
- R11: The index used by the walking-one and index patterns restarts at 0 for every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| sampledMode | input | 1 | 1 selects boundary-window coverage, 0 selects the whole region |
| baseAddr | input | ADDR_W | Byte address where the region starts |
| regionBytes | input | ADDR_W | Region size in bytes |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, one cycle after the read |
| wdogKick | output | 1 | Watchdog service pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| passed | output | 1 | Last run matched everywhere |
| failed | output | 1 | Last run found a mismatch |
| failAddr | output | ADDR_W | Byte address of the failing word |
| failExp | output | DATA_W | Value written there |
| failGot | output | DATA_W | Value read back |

## Verification
The hardest case to reach is a mismatch on the last word of a window, where the compare lands in the drain cycle rather than under a following read. It is also hard to make a failure land in the second window of a later block in sampled mode. The bench gets there with a behavioural memory that has one faulty word. The bit is forced high or low at an address chosen so that the first disagreement falls on a window's final word, or inside the upper window of the second 1 MiB block. The reference model predicts every cycle from the pattern formulas and the fault. It also pokes `start` in the middle of a long run to show that the stream of accesses is unchanged.

// File: rtl/pfvPkg.sv
package pfvPkg;

  localparam int unsigned PASS_COUNT = 7;
  localparam int unsigned PASS_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_VERIFY,
    ST_DRAIN,
    ST_GAP
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch run inputs, clear result fields
    logic wr;       // issue a write of the current word
    logic rd;       // issue a read of the current word
    logic capFail;  // capture the pending compare as the failure record
  } seqStrobe_t;

endpackage

// File: rtl/pfvCtrl.sv
module pfvCtrl
  import pfvPkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BLOCK_SHIFT = 20,
  parameter int unsigned WIN_BYTES   = 2048,
  parameter int unsigned KICK_SHIFT  = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic                           sampledMode,
  input  logic [ADDR_W-1:0]              regionBytes,
  input  logic                           mismatch,
  output seqStrobe_t                     strb,
  output logic [ADDR_W-3:0]              idx,
  output logic [PASS_W-1:0]              passNo,
  output logic [ADDR_W-BLOCK_SHIFT:0]    winIdx,
  output logic                           modeQ,
  output logic                           busy,
  output logic                           done,
  output logic                           passed,
  output logic                           failed,
  output logic                           wdogKick
);

  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam int unsigned WIN_W     = ADDR_W - BLOCK_SHIFT + 1;
  localparam int unsigned BLK_W     = WIN_W - 1;
  localparam int unsigned WIN_WORDS = WIN_BYTES / 4;

  seqState_e         state;
  logic [IDX_W-1:0]  wordsLast;
  logic [WIN_W-1:0]  winLast;
  logic [IDX_W-1:0]  wordCnt;
  logic [BLK_W-1:0]  blkCnt;
  logic [WIN_W-1:0]  winCnt;
  logic              emptyRun;
  logic              lastPass;

  always_comb begin
    blkCnt   = BLK_W'(regionBytes >> BLOCK_SHIFT);
    wordCnt  = sampledMode ? IDX_W'(WIN_WORDS) : IDX_W'(regionBytes >> 2);
    winCnt   = sampledMode ? {blkCnt, 1'b0} : WIN_W'(1);
    emptyRun = (wordCnt == '0) || (winCnt == '0);
    lastPass = (passNo == PASS_W'(PASS_COUNT - 1));
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && start;
    strb.wr      = (state == ST_FILL);
    strb.rd      = (state == ST_VERIFY);
    strb.capFail = ((state == ST_VERIFY) || (state == ST_DRAIN)) && mismatch;
  end

  assign busy     = (state != ST_IDLE);
  assign wdogKick = (((state == ST_FILL) || (state == ST_VERIFY)) &&
                     (idx[KICK_SHIFT-1:0] == '0)) || (state == ST_GAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      passNo    <= '0;
      winIdx    <= '0;
      wordsLast <= '0;
      winLast   <= '0;
      modeQ     <= 1'b0;
      done      <= 1'b0;
      passed    <= 1'b0;
      failed    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            modeQ     <= sampledMode;
            wordsLast <= wordCnt - IDX_W'(1);
            winLast   <= winCnt - WIN_W'(1);
            idx       <= '0;
            passNo    <= '0;
            winIdx    <= '0;
            passed    <= 1'b0;
            failed    <= 1'b0;
            if (emptyRun) begin
              done   <= 1'b1;
              passed <= 1'b1;
            end else begin
              state <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (idx == wordsLast) begin
            idx   <= '0;
            state <= ST_VERIFY;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_VERIFY: begin
          if (mismatch) begin
            failed <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else if (idx == wordsLast) begin
            idx   <= '0;
            state <= ST_DRAIN;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_DRAIN: begin
          if (mismatch) begin
            failed <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (lastPass) begin
            passNo <= '0;
            if (winIdx == winLast) begin
              passed <= 1'b1;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              winIdx <= winIdx + WIN_W'(1);
              state  <= ST_FILL;
            end
          end else begin
            passNo <= passNo + PASS_W'(1);
            state  <= ST_FILL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pfvDatapath.sv
module pfvDatapath
  import pfvPkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BLOCK_SHIFT = 20,
  parameter int unsigned WIN_BYTES   = 2048
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    strb,
  input  logic [ADDR_W-3:0]             idx,
  input  logic [PASS_W-1:0]             passNo,
  input  logic [ADDR_W-BLOCK_SHIFT:0]   winIdx,
  input  logic                          modeQ,
  input  logic [ADDR_W-1:0]             baseAddr,
  input  logic [DATA_W-1:0]             memRdata,
  output logic                          memReq,
  output logic                          memWe,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [DATA_W-1:0]             memWdata,
  output logic                          mismatch,
  output logic [ADDR_W-1:0]             failAddr,
  output logic [DATA_W-1:0]             failExp,
  output logic [DATA_W-1:0]             failGot
);

  localparam int unsigned WIN_W = ADDR_W - BLOCK_SHIFT + 1;
  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] UPPER_OFS =
    ADDR_W'((64'd1 << BLOCK_SHIFT) - 64'(WIN_BYTES));
  localparam logic [DATA_W-1:0] CHECK_A = {(DATA_W/2){2'b01}};
  localparam logic [DATA_W-1:0] CHECK_B = {(DATA_W/2){2'b10}};

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] winBase;
  logic [ADDR_W-1:0] wordAddr;
  logic [DATA_W-1:0] idxWord;
  logic [DATA_W-1:0] patWord;
  logic              cmpValid;
  logic [DATA_W-1:0] cmpExp;
  logic [ADDR_W-1:0] cmpAddr;

  // window origin: whole region, or lower/upper slice of block winIdx>>1
  always_comb begin
    if (modeQ) begin
      winBase = baseQ + (ADDR_W'(winIdx[WIN_W-1:1]) << BLOCK_SHIFT) +
                (winIdx[0] ? UPPER_OFS : '0);
    end else begin
      winBase = baseQ;
    end
    wordAddr = winBase + {idx, 2'b00};
  end

  always_comb begin
    idxWord = DATA_W'(idx);
    unique case (passNo)
      3'd0:    patWord = '0;
      3'd1:    patWord = '1;
      3'd2:    patWord = CHECK_A;
      3'd3:    patWord = CHECK_B;
      3'd4:    patWord = DATA_W'(1) << idx[SH_W-1:0];
      3'd5:    patWord = idxWord;
      3'd6:    patWord = ~idxWord;
      default: patWord = '0;
    endcase
  end

  assign memReq   = strb.wr | strb.rd;
  assign memWe    = strb.wr;
  assign memAddr  = wordAddr;
  assign memWdata = strb.wr ? patWord : '0;
  assign mismatch = cmpValid && (memRdata != cmpExp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ    <= '0;
      cmpValid <= 1'b0;
      cmpExp   <= '0;
      cmpAddr  <= '0;
      failAddr <= '0;
      failExp  <= '0;
      failGot  <= '0;
    end else begin
      cmpValid <= strb.rd;
      if (strb.rd) begin
        cmpExp  <= patWord;
        cmpAddr <= wordAddr;
      end
      if (strb.load) begin
        baseQ    <= baseAddr;
        failAddr <= '0;
        failExp  <= '0;
        failGot  <= '0;
      end else if (strb.capFail) begin
        failAddr <= cmpAddr;
        failExp  <= cmpExp;
        failGot  <= memRdata;
      end
    end
  end

endmodule

// File: rtl/patternFillVerify.sv
module patternFillVerify
  import pfvPkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BLOCK_SHIFT = 20,
  parameter int unsigned WIN_BYTES   = 2048,
  parameter int unsigned KICK_SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              sampledMode,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] regionBytes,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              wdogKick,
  output logic              busy,
  output logic              done,
  output logic              passed,
  output logic              failed,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failGot
);

  seqStrobe_t                  strb;
  logic [ADDR_W-3:0]           idx;
  logic [PASS_W-1:0]           passNo;
  logic [ADDR_W-BLOCK_SHIFT:0] winIdx;
  logic                        modeQ;
  logic                        mismatch;

  pfvCtrl #(
    .ADDR_W(ADDR_W), .BLOCK_SHIFT(BLOCK_SHIFT),
    .WIN_BYTES(WIN_BYTES), .KICK_SHIFT(KICK_SHIFT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .sampledMode(sampledMode),
    .regionBytes(regionBytes), .mismatch(mismatch), .strb(strb),
    .idx(idx), .passNo(passNo), .winIdx(winIdx), .modeQ(modeQ),
    .busy(busy), .done(done), .passed(passed), .failed(failed),
    .wdogKick(wdogKick)
  );

  pfvDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BLOCK_SHIFT(BLOCK_SHIFT), .WIN_BYTES(WIN_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx), .passNo(passNo),
    .winIdx(winIdx), .modeQ(modeQ), .baseAddr(baseAddr),
    .memRdata(memRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .mismatch(mismatch),
    .failAddr(failAddr), .failExp(failExp), .failGot(failGot)
  );

endmodule

// File: rtl/patternFillVerifyChk.sv
module patternFillVerifyChk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              wdogKick,
  input logic              busy,
  input logic              done,
  input logic              passed,
  input logic              failed,
  input logic [ADDR_W-1:0] failAddr,
  input logic [DATA_W-1:0] failExp,
  input logic [DATA_W-1:0] failGot
);

  // R1 / R5: no traffic and no kick while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !wdogKick));

  // R9: done lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: end of run always announced
  assert_done_on_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R4 / R9: verdict flags are exclusive
  assert_verdict_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({passed, failed}));

  // R3: back-to-back writes step by one word
  assert_fill_ascend_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && $past(memReq && memWe)) |->
      (memAddr == $past(memAddr) + ADDR_W'(4)));

  // R3: back-to-back reads step by one word
  assert_read_ascend_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && $past(memReq && !memWe)) |->
      (memAddr == $past(memAddr) + ADDR_W'(4)));

  // R8: failure record frozen until a new start
  assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (failed && !start) |=>
      (failed && $stable(failAddr) && $stable(failExp) && $stable(failGot)));

endmodule

bind patternFillVerify patternFillVerifyChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (.*);

// File: tb/sim_patternFillVerify.sv
`timescale 1ns/1ps
module sim_patternFillVerify;

  localparam int WD_LIMIT = 195000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        sampledMode = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [31:0] regionBytes = '0;
  logic        memReq, memWe, wdogKick, busy, done, passed, failed;
  logic [31:0] memAddr, memWdata, failAddr, failExp, failGot;
  logic [31:0] memRdata = '0;

  int checkCnt = 0;
  int failCnt = 0;
  int cycleCnt = 0;
  int stepNo = 0;
  int pokeIdx = -1;

  bit          ePassed, eFailed;
  logic [31:0] eFA, eFE, eFG;

  bit          faultOn = 0;
  logic [31:0] faultAddr = '0, faultSet = '0, faultClr = '0;
  logic [31:0] memArr [int unsigned];

  always #2.5 clk = ~clk;

  patternFillVerify u0 (
    .clk(clk), .rstN(rstN), .start(start), .sampledMode(sampledMode),
    .baseAddr(baseAddr), .regionBytes(regionBytes), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .wdogKick(wdogKick), .busy(busy), .done(done),
    .passed(passed), .failed(failed), .failAddr(failAddr),
    .failExp(failExp), .failGot(failGot)
  );

  function automatic logic [31:0] applyFault(input logic [31:0] a, input logic [31:0] v);
    if (faultOn && a == faultAddr) return (v | faultSet) & ~faultClr;
    return v;
  endfunction

  // behavioural memory, one cycle read latency
  always @(posedge clk) begin
    if (memReq && memWe) memArr[memAddr >> 2] = memWdata;
    else if (memReq) begin
      if (memArr.exists(memAddr >> 2)) memRdata <= applyFault(memAddr, memArr[memAddr >> 2]);
      else memRdata <= applyFault(memAddr, 32'h0);
    end
  end

  function automatic logic [31:0] expPat(input int p, input int i);
    case (p)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h5555_5555;
      3: return 32'hAAAA_AAAA;
      4: return 32'h1 << (i % 32);
      5: return 32'(i);
      default: return ~32'(i);
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > WD_LIMIT) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run did not finish (R9), got cycles=%0d exp <=%0d", cycleCnt, WD_LIMIT);
      summary();
      $finish;
    end
  end

  // one reference cycle: compare at negedge, then move to the next negedge
  task automatic step(input bit eBusy, input bit eDone, input bit eReq, input bit eWe,
                      input logic [31:0] eAddr, input logic [31:0] eWd, input bit eKick,
                      input string ctx);
    bit ok;
    ok = (busy === eBusy) && (done === eDone) && (passed === ePassed) &&
         (failed === eFailed) && (memReq === eReq) && (wdogKick === eKick) &&
         (failAddr === eFA) && (failExp === eFE) && (failGot === eFG);
    if (eReq) ok = ok && (memWe === eWe) && (memAddr === eAddr);
    if (eReq && eWe) ok = ok && (memWdata === eWd);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s step %0d: busy/done/passed/failed/req/we/kick got %b%b%b%b%b%b%b exp %b%b%b%b%b%b%b addr got %h exp %h wdata got %h exp %h failrec got %h/%h/%h exp %h/%h/%h",
               ctx, stepNo, busy, done, passed, failed, memReq, memWe, wdogKick,
               eBusy, eDone, ePassed, eFailed, eReq, eWe, eKick,
               memAddr, eAddr, memWdata, eWd, failAddr, failExp, failGot, eFA, eFE, eFG);
    end
    start = (stepNo == pokeIdx);
    stepNo++;
    @(negedge clk);
  endtask

  task automatic runTest(input bit smp, input logic [31:0] base, input logic [31:0] bytes,
                         input int pokeAt, input string ctx);
    logic [31:0] wb[$];
    int          words;
    logic [31:0] a, pat, got;
    if (smp) begin
      words = 512;
      for (int b = 0; b < int'(bytes >> 20); b++) begin
        wb.push_back(base + (32'(b) << 20));
        wb.push_back(base + (32'(b) << 20) + 32'h000F_F800);
      end
    end else begin
      words = int'(bytes >> 2);
      wb.push_back(base);
    end
    sampledMode = smp;
    baseAddr    = base;
    regionBytes = bytes;
    start       = 1'b1;
    pokeIdx     = pokeAt;
    stepNo      = 0;
    @(negedge clk);
    ePassed = 0; eFailed = 0; eFA = '0; eFE = '0; eFG = '0;
    if (words == 0 || wb.size() == 0) begin
      ePassed = 1;
      step(0, 1, 0, 0, '0, '0, 0, {ctx, " R9 empty"});
      step(0, 0, 0, 0, '0, '0, 0, {ctx, " R9 after"});
      return;
    end
    foreach (wb[w]) begin
      for (int p = 0; p < 7; p++) begin
        for (int i = 0; i < words; i++) begin
          a = wb[w] + 32'(4 * i);
          step(1, 0, 1, 1, a, expPat(p, i), (i % 1024) == 0, {ctx, " R2 R3 R5 R11 fill"});
        end
        for (int i = 0; i < words; i++) begin
          a   = wb[w] + 32'(4 * i);
          pat = expPat(p, i);
          got = applyFault(a, pat);
          step(1, 0, 1, 0, a, '0, (i % 1024) == 0, {ctx, " R3 R5 verify"});
          if (got !== pat) begin
            if (i < words - 1)
              step(1, 0, 1, 0, a + 32'd4, '0, ((i + 1) % 1024) == 0, {ctx, " R4 last read"});
            else
              step(1, 0, 0, 0, '0, '0, 0, {ctx, " R4 drain"});
            eFailed = 1; eFA = a; eFE = pat; eFG = got;
            step(0, 1, 0, 0, '0, '0, 0, {ctx, " R4 R8 R9 fail end"});
            step(0, 0, 0, 0, '0, '0, 0, {ctx, " R8 R9 hold"});
            step(0, 0, 0, 0, '0, '0, 0, {ctx, " R8 hold"});
            return;
          end
        end
        step(1, 0, 0, 0, '0, '0, 0, {ctx, " R3 drain"});
        step(1, 0, 0, 0, '0, '0, 1, {ctx, " R5 gap kick"});
      end
    end
    ePassed = 1;
    step(0, 1, 0, 0, '0, '0, 0, {ctx, " R9 pass end"});
    step(0, 0, 0, 0, '0, '0, 0, {ctx, " R9 single pulse"});
  endtask

  initial begin
    ePassed = 0; eFailed = 0; eFA = '0; eFE = '0; eFG = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 0, '0, '0, 0, "R1 reset state");
    step(0, 0, 0, 0, '0, '0, 0, "R1 idle");

    // R7, R5: full region of 2100 words, kicks at 0/1024/2048
    runTest(0, 32'h0000_1000, 32'd8400, -1, "R7 full");

    // R4: stuck-high bit caught by the zero pattern mid-window
    faultOn = 1; faultAddr = 32'h0000_3014; faultSet = 32'h8; faultClr = 0;
    runTest(0, 32'h0000_3000, 32'd256, -1, "R4 stuck-high");

    // R4: stuck-low bit on the last word, caught in drain during the all-ones pass
    faultAddr = 32'h0000_209C; faultSet = 0; faultClr = 32'h1;
    runTest(0, 32'h0000_2000, 32'd160, -1, "R4 last-word");

    // R8: a passing run clears the failure record; R10 start poked while busy
    faultOn = 0;
    runTest(1, 32'h4000_0000, 32'h0020_0100, 700, "R6 R10 R11 sampled");

    // R6: failure inside the upper window of the second block
    faultOn = 1; faultAddr = 32'h1000_0000 + 32'h0010_0000 + 32'h000F_F800 + 32'd8;
    faultSet = 32'h10; faultClr = 0;
    runTest(1, 32'h1000_0000, 32'h0020_0000, -1, "R6 R8 sampled fail");
    faultOn = 0;

    // R9: empty regions
    runTest(1, 32'h0000_0000, 32'h000F_FFFC, -1, "R9 sampled tiny");
    runTest(0, 32'h0000_0000, 32'h0000_0000, -1, "R9 full zero");

    summary();
    $finish;
  end

endmodule